// File: doc/BRIEF.md
# Increment-and-Skip Execution Unit

This block is a small two-stage core that fetches one 16-bit word per cycle into a prefetch register and executes the word held there in the following cycle. It understands two byte-oriented instructions. Both read an 8-bit file register, add one, and send the sum either to the working register or back to the file register. One instruction skips the next instruction when the sum is zero. The other skips it when the sum is not zero. A skip turns the word that has already been prefetched into an empty slot. When that word starts a two-word instruction, its second word is emptied as well. Every other opcode executes as a no-op.

The data address is 12 bits wide. It is built from the 8-bit file field of the opcode, a per-instruction bank-mode bit and a 4-bit bank number that the surrounding logic supplies. The file storage is a register-file model. It holds a set number of general banks plus the special-function bank. A side port lets the surrounding logic preload and inspect that storage. Fetch never stalls: the program counter advances on every cycle, and a skip is paid for only in emptied execute slots.

Top module: `incskip_core`

## Requirements
- R1: An opcode whose top six bits are 001111 is the skip-on-zero increment, and one whose top six bits are 010010 is the skip-on-nonzero increment. In both, bit 9 is the destination bit, bit 8 is the bank-mode bit and bits 7:0 are the file field. Any other opcode leaves the working register, the file storage and the slot indicator unchanged.
- R2: The result is the 8-bit operand plus one, modulo 256, so 0xFF becomes 0x00.
- R3: With bit 9 at 0 the result is loaded into the working register and the file register is unchanged. With bit 9 at 1 the result is written back to the file register and the working register is unchanged.
- R4: With bit 8 at 0, file fields 0x00 to 0x7F address 0x000 to 0x07F and file fields 0x80 to 0xFF address 0xF80 to 0xFFF, whatever the bank input is. With bit 8 at 1, the address is {bank, file field}.
- R5: The skip-on-zero instruction skips when the result is 0x00. The skip-on-nonzero instruction skips when the result is anything else.
- R6: A skip over a one-word instruction asserts `slotSquashed` for exactly one cycle, starting in the cycle after the increment executes.
- R7: A skip over a word whose top four bits are 1100, 1110 or 1111 asserts `slotSquashed` for exactly two consecutive cycles.
- R8: An instruction in an emptied slot changes neither the working register nor the file storage, and `pc` increases by one on every cycle out of reset.
- R9: While reset is held, `pc` is 0, `wreg` is 0 and `slotSquashed` is 0. The first cycle after reset executes nothing.
- R10: An address whose bank is neither an implemented general bank (below GPR_BANKS) nor bank 15 reads as 0x00, and writes to it from either the core or the side port are dropped.
- R11: The side port writes `rfWdata` at address `rfAddr` on a clock edge when `rfWe` is 1. `rfRdata` shows the byte at `rfAddr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction slot per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| bankSel | input | 4 | Bank number used when the bank-mode bit is 1 |
| instrWord | input | 16 | Program word at address `pc` |
| pc | output | 12 | Fetch address |
| wreg | output | 8 | Working register |
| slotSquashed | output | 1 | The current execute slot holds a skipped word |
| rfWe | input | 1 | Side-port write enable |
| rfAddr | input | 12 | Side-port address |
| rfWdata | input | 8 | Side-port write data |
| rfRdata | output | 8 | Side-port read data |

## Verification
The assertions assume that `instrWord` is a settled combinational image of the program at `pc`. They also assume that the side port writes only while reset is held, so it never competes with a core write. The bench drives `rfWe` only inside its reset window, and it changes the program and the bank input only while the core is in reset. The two-word checks expect the second word of such an instruction to decode as a no-op. Every program in the bench therefore places a word with top nibble 1111 after a 1100 or 1110 word, and fills unused locations with 0x0000.

// File: rtl/incskip_pkg.sv
package incskip_pkg;

  localparam int INSTR_W = 16;
  localparam int FIELD_W = 8;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SKZ  = 2'd1,
    OP_SKNZ = 2'd2
  } opKind_t;

  // Strobes from control to datapath for the current execute slot
  typedef struct packed {
    logic               execEn;
    logic               toFile;
    logic               banked;
    logic [FIELD_W-1:0] fileSel;
  } dpCtrl_t;

  function automatic opKind_t decodeOp(input logic [INSTR_W-1:0] w);
    if (w[15:10] == 6'b001111)      return OP_SKZ;
    else if (w[15:10] == 6'b010010) return OP_SKNZ;
    else                            return OP_NONE;
  endfunction

  function automatic logic isTwoWord(input logic [INSTR_W-1:0] w);
    return (w[15:12] == 4'b1100) || (w[15:12] == 4'b1110) ||
           (w[15:12] == 4'b1111);
  endfunction

endpackage

// File: rtl/incskip_regfile.sv
module incskip_regfile #(
  parameter int BANK_W    = 4,
  parameter int FILE_W    = 8,
  parameter int DATA_W    = 8,
  parameter int GPR_BANKS = 4,
  parameter int SFR_BANK  = 15
) (
  input  logic                     clk,
  input  logic [BANK_W+FILE_W-1:0] coreAddr,
  input  logic                     coreWe,
  input  logic [DATA_W-1:0]        coreWdata,
  output logic [DATA_W-1:0]        coreRdata,
  input  logic [BANK_W+FILE_W-1:0] sideAddr,
  input  logic                     sideWe,
  input  logic [DATA_W-1:0]        sideWdata,
  output logic [DATA_W-1:0]        sideRdata
);

  localparam int ADDR_W = BANK_W + FILE_W;
  localparam int SLOTS  = GPR_BANKS + 1;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = SLOT_W + FILE_W;
  localparam int DEPTH  = SLOTS * (1 << FILE_W);
  localparam int PORTS  = 2;

  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] portAddr [PORTS];
  logic [DATA_W-1:0] portData [PORTS];
  logic              portHit  [PORTS];
  logic [IDX_W-1:0]  portIdx  [PORTS];

  assign portAddr[0] = coreAddr;
  assign portAddr[1] = sideAddr;

  // Bank number to physical slot: general banks first, the special bank last
  function automatic logic [IDX_W:0] locate(input logic [ADDR_W-1:0] a);
    logic [BANK_W-1:0] bank;
    logic [SLOT_W-1:0] slot;
    logic              hit;
    bank = a[ADDR_W-1:FILE_W];
    if (bank == BANK_W'(SFR_BANK)) begin
      slot = SLOT_W'(GPR_BANKS);
      hit  = 1'b1;
    end else if (int'(bank) < GPR_BANKS) begin
      slot = SLOT_W'(bank);
      hit  = 1'b1;
    end else begin
      slot = '0;
      hit  = 1'b0;
    end
    return {hit, slot, a[FILE_W-1:0]};
  endfunction

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [IDX_W:0] loc;
    assign loc         = locate(portAddr[p]);
    assign portHit[p]  = loc[IDX_W];
    assign portIdx[p]  = loc[IDX_W-1:0];
    assign portData[p] = portHit[p] ? mem[portIdx[p]] : '0;
  end

  assign coreRdata = portData[0];
  assign sideRdata = portData[1];

  always_ff @(posedge clk) begin
    if (coreWe && portHit[0]) begin
      mem[portIdx[0]] <= coreWdata;
    end else if (sideWe && portHit[1]) begin
      mem[portIdx[1]] <= sideWdata;
    end
  end

endmodule

// File: rtl/incskip_ctrl.sv
module incskip_ctrl
  import incskip_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               resultZero,
  output logic [PC_W-1:0]    pc,
  output dpCtrl_t            dpCtrl,
  output logic               slotSquashed
);

  logic [PC_W-1:0]    pcQ;
  logic [INSTR_W-1:0] prefQ;
  logic               prefValidQ;
  logic [1:0]         squashCntQ;

  opKind_t kind;
  logic    live;
  logic    execNow;
  logic    skipNow;

  assign kind    = decodeOp(prefQ);
  assign live    = prefValidQ && (squashCntQ == 2'd0);
  assign execNow = live && (kind != OP_NONE);
  assign skipNow = execNow &&
                   (((kind == OP_SKZ)  &&  resultZero) ||
                    ((kind == OP_SKNZ) && !resultZero));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ        <= '0;
      prefQ      <= '0;
      prefValidQ <= 1'b0;
      squashCntQ <= 2'd0;
    end else begin
      pcQ        <= pcQ + PC_W'(1);
      prefQ      <= instrWord;
      prefValidQ <= 1'b1;
      if (skipNow) begin
        // The word being fetched now is the one skipped
        squashCntQ <= isTwoWord(instrWord) ? 2'd2 : 2'd1;
      end else if (squashCntQ != 2'd0) begin
        squashCntQ <= squashCntQ - 2'd1;
      end
    end
  end

  assign pc           = pcQ;
  assign slotSquashed = prefValidQ && (squashCntQ != 2'd0);

  always_comb begin
    dpCtrl.execEn  = execNow;
    dpCtrl.toFile  = prefQ[9];
    dpCtrl.banked  = prefQ[8];
    dpCtrl.fileSel = prefQ[FIELD_W-1:0];
  end

endmodule

// File: rtl/incskip_dp.sv
module incskip_dp
  import incskip_pkg::*;
#(
  parameter int BANK_W    = 4,
  parameter int DATA_W    = 8,
  parameter int GPR_BANKS = 4,
  parameter int SFR_BANK  = 15
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtrl_t                   dpCtrl,
  input  logic [BANK_W-1:0]         bankSel,
  output logic [DATA_W-1:0]         wreg,
  output logic                      resultZero,
  input  logic                      rfWe,
  input  logic [BANK_W+FIELD_W-1:0] rfAddr,
  input  logic [DATA_W-1:0]         rfWdata,
  output logic [DATA_W-1:0]         rfRdata
);

  localparam int ADDR_W = BANK_W + FIELD_W;
  localparam logic [FIELD_W-1:0] SPLIT = FIELD_W'(1 << (FIELD_W - 1));

  logic [ADDR_W-1:0] effAddr;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] result;
  logic [BANK_W-1:0] accessBank;

  // Bank-mode 0 splits the file field between bank 0 and the special bank
  assign accessBank = (dpCtrl.fileSel >= SPLIT) ? BANK_W'(SFR_BANK) : '0;
  assign effAddr    = dpCtrl.banked ? {bankSel, dpCtrl.fileSel}
                                    : {accessBank, dpCtrl.fileSel};

  assign result     = operand + DATA_W'(1);
  assign resultZero = (result == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wreg <= '0;
    end else if (dpCtrl.execEn && !dpCtrl.toFile) begin
      wreg <= result;
    end
  end

  incskip_regfile #(
    .BANK_W   (BANK_W),
    .FILE_W   (FIELD_W),
    .DATA_W   (DATA_W),
    .GPR_BANKS(GPR_BANKS),
    .SFR_BANK (SFR_BANK)
  ) u_rf (
    .clk      (clk),
    .coreAddr (effAddr),
    .coreWe   (dpCtrl.execEn && dpCtrl.toFile),
    .coreWdata(result),
    .coreRdata(operand),
    .sideAddr (rfAddr),
    .sideWe   (rfWe),
    .sideWdata(rfWdata),
    .sideRdata(rfRdata)
  );

endmodule

// File: rtl/incskip_core.sv
module incskip_core
  import incskip_pkg::*;
#(
  parameter int PC_W      = 12,
  parameter int BANK_W    = 4,
  parameter int DATA_W    = 8,
  parameter int GPR_BANKS = 4,
  parameter int SFR_BANK  = 15
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [BANK_W-1:0]         bankSel,
  input  logic [INSTR_W-1:0]        instrWord,
  output logic [PC_W-1:0]           pc,
  output logic [DATA_W-1:0]         wreg,
  output logic                      slotSquashed,
  input  logic                      rfWe,
  input  logic [BANK_W+FIELD_W-1:0] rfAddr,
  input  logic [DATA_W-1:0]         rfWdata,
  output logic [DATA_W-1:0]         rfRdata
);

  dpCtrl_t dpCtrl;
  logic    resultZero;

  incskip_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .instrWord   (instrWord),
    .resultZero  (resultZero),
    .pc          (pc),
    .dpCtrl      (dpCtrl),
    .slotSquashed(slotSquashed)
  );

  incskip_dp #(
    .BANK_W   (BANK_W),
    .DATA_W   (DATA_W),
    .GPR_BANKS(GPR_BANKS),
    .SFR_BANK (SFR_BANK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtrl    (dpCtrl),
    .bankSel   (bankSel),
    .wreg      (wreg),
    .resultZero(resultZero),
    .rfWe      (rfWe),
    .rfAddr    (rfAddr),
    .rfWdata   (rfWdata),
    .rfRdata   (rfRdata)
  );

endmodule

// File: rtl/incskip_sva.sv
module incskip_sva
  import incskip_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int DATA_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [INSTR_W-1:0] instrWord,
  input logic [PC_W-1:0]    pc,
  input logic [DATA_W-1:0]  wreg,
  input logic               slotSquashed
);

  // R9: reset state seen at every edge while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      a_reset_state_r9: assert (pc == '0 && wreg == '0 && !slotSquashed);
    end
  end

  // R8: fetch never stalls
  p_pc_advance_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> pc == $past(pc) + PC_W'(1));

  // R8: an emptied slot leaves the working register alone
  p_squash_keeps_w_r8: assert property (@(posedge clk) disable iff (!rstN)
    slotSquashed |=> wreg == $past(wreg));

  // R6: skipping a one-word instruction empties exactly one slot
  p_one_word_penalty_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(slotSquashed) && !isTwoWord($past(instrWord))) |=> !slotSquashed);

  // R7: skipping a two-word instruction empties a second slot
  p_two_word_penalty_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(slotSquashed) && isTwoWord($past(instrWord))) |=> slotSquashed);

  // R7: never more than two emptied slots in a row
  p_squash_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (slotSquashed && $past(slotSquashed)) |=> !slotSquashed);

endmodule

bind incskip_core incskip_sva #(.PC_W(PC_W), .DATA_W(DATA_W)) u_sva (
  .clk         (clk),
  .rstN        (rstN),
  .instrWord   (instrWord),
  .pc          (pc),
  .wreg        (wreg),
  .slotSquashed(slotSquashed)
);

// File: tb/tb_incskip_core.sv
module tb_incskip_core;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  bankSel = '0;
  logic [15:0] instrWord;
  logic [11:0] pc;
  logic [7:0]  wreg;
  logic        slotSquashed;
  logic        rfWe = 1'b0;
  logic [11:0] rfAddr = '0;
  logic [7:0]  rfWdata = '0;
  logic [7:0]  rfRdata;

  logic [15:0] prog [16];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign instrWord = prog[pc[3:0]];

  incskip_core dut (
    .clk(clk), .rstN(rstN), .bankSel(bankSel), .instrWord(instrWord),
    .pc(pc), .wreg(wreg), .slotSquashed(slotSquashed),
    .rfWe(rfWe), .rfAddr(rfAddr), .rfWdata(rfWdata), .rfRdata(rfRdata)
  );

  // Fields: nz, d, a, bank[4], f[8], preload[8], nextIsTwoWord
  localparam int NV = 10;
  localparam logic [23:0] VECS [NV] = '{
    {1'b0, 1'b1, 1'b0, 4'h0, 8'h10, 8'h05, 1'b0},
    {1'b0, 1'b1, 1'b0, 4'h0, 8'h20, 8'hFF, 1'b0},
    {1'b0, 1'b1, 1'b0, 4'h0, 8'h21, 8'hFF, 1'b1},
    {1'b1, 1'b0, 1'b0, 4'h0, 8'h30, 8'h41, 1'b0},
    {1'b1, 1'b1, 1'b1, 4'h2, 8'h30, 8'hFF, 1'b0},
    {1'b1, 1'b1, 1'b1, 4'h1, 8'h90, 8'h7F, 1'b1},
    {1'b0, 1'b0, 1'b0, 4'h3, 8'h85, 8'hFF, 1'b0},
    {1'b0, 1'b1, 1'b1, 4'hF, 8'h05, 8'h00, 1'b0},
    {1'b1, 1'b1, 1'b0, 4'h0, 8'hFF, 8'h10, 1'b1},
    {1'b0, 1'b1, 1'b1, 4'h0, 8'h7F, 8'hFE, 1'b0}
  };

  function automatic logic [11:0] refAddr(input logic a, input logic [3:0] b,
                                          input logic [7:0] f);
    if (a) return {b, f};
    return (f >= 8'h80) ? {4'hF, f} : {4'h0, f};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic enterReset();
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < 16; i++) prog[i] = 16'h0000;
    @(negedge clk);
  endtask

  task automatic poke(input logic [11:0] a, input logic [7:0] d);
    rfAddr = a; rfWdata = d; rfWe = 1'b1;
    @(negedge clk);
    rfWe = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [7:0] d);
    rfAddr = a;
    #0.5;
    d = rfRdata;
  endtask

  // Release reset at a falling edge and run eight slots
  task automatic runSlots(output int sq);
    rstN = 1'b1;
    sq = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (slotSquashed) sq++;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sq;
    logic [7:0] rd;
    for (int i = 0; i < 16; i++) prog[i] = 16'h0000;
    rstN = 1'b1;
    #1 rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R9: reset values
    check("R9 pc in reset", int'(pc), 0);
    check("R9 wreg in reset", int'(wreg), 0);
    check("R9 squash in reset", int'(slotSquashed), 0);

    // R11: side port write then read back
    poke(12'h123, 8'hA5);
    peek(12'h123, rd);
    check("R11 side port readback", int'(rd), 'hA5);

    // Table walk: R1 R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic nz, d, a, two, skip;
      logic [3:0] b;
      logic [7:0] f, pre, res;
      logic [11:0] ad;
      {nz, d, a, b, f, pre, two} = VECS[v];
      ad = refAddr(a, b, f);
      res = pre + 8'd1;
      skip = nz ? (res != 8'd0) : (res == 8'd0);
      enterReset();
      bankSel = b;
      prog[0] = {(nz ? 6'b010010 : 6'b001111), d, a, f};
      prog[1] = two ? 16'hC123 : 16'h0000;
      prog[2] = two ? 16'hF456 : 16'h0000;
      poke(ad, pre);
      runSlots(sq);
      peek(ad, rd);
      check($sformatf("R3 R4 R2 file vec %0d", v), int'(rd), int'(d ? res : pre));
      check($sformatf("R3 R2 wreg vec %0d", v), int'(wreg), int'(d ? 8'd0 : res));
      check($sformatf("R5 R6 R7 squash count vec %0d", v), sq,
            skip ? (two ? 2 : 1) : 0);
    end

    // R8: chained increments, squashed words have no effect, pc keeps going
    enterReset();
    bankSel = 4'h0;
    prog[0] = 16'h3E40;
    prog[1] = 16'h3E40;
    prog[2] = 16'h4841;
    prog[3] = 16'h4A41;
    prog[4] = 16'h3E40;
    poke(12'h040, 8'hFE);
    poke(12'h041, 8'h07);
    runSlots(sq);
    check("R8 pc after eight slots", int'(pc), 8);
    check("R8 squash count in chain", sq, 2);
    check("R8 squashed word kept wreg", int'(wreg), 0);
    peek(12'h040, rd);
    check("R8 squashed word kept file", int'(rd), 0);
    peek(12'h041, rd);
    check("R8 chain second target", int'(rd), 8'h08);

    // R1: other opcodes do nothing
    enterReset();
    prog[0] = 16'h2A50;
    prog[1] = 16'h3A50;
    prog[2] = 16'h4C50;
    poke(12'h050, 8'hFF);
    runSlots(sq);
    peek(12'h050, rd);
    check("R1 foreign opcode file", int'(rd), 'hFF);
    check("R1 foreign opcode wreg", int'(wreg), 0);
    check("R1 foreign opcode squash", sq, 0);

    // R10: unimplemented bank reads zero and drops writes
    enterReset();
    bankSel = 4'h6;
    prog[0] = 16'h4B10;
    poke(12'h610, 8'h55);
    peek(12'h610, rd);
    check("R10 side write dropped", int'(rd), 0);
    runSlots(sq);
    peek(12'h610, rd);
    check("R10 core write dropped", int'(rd), 0);
    check("R10 zero read gives nonzero skip", sq, 1);

    enterReset();
    bankSel = 4'h9;
    prog[0] = 16'h4910;
    runSlots(sq);
    check("R10 W from unimplemented bank", int'(wreg), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule